// File: doc/BRIEF.md
# Byte Transmit Queue with Depth-Revealing Watermark

This block is a first-in, first-out queue of bytes placed between a register bus and a serial shift engine. The bus side pushes bytes one per cycle. The engine side pops them one per cycle, and it sees the oldest byte at the head of the queue before it pops. The block reports whether the queue is full or empty. It also reports whether the fill level has dropped below a programmable watermark, which tells software when to refill the queue.

The watermark register holds only as many bits as it needs to store depth minus one. Any wider value that software writes is cut down to those low bits. Software can therefore learn the depth that was built by writing all ones to the register and reading it back. The depth is a power-of-two parameter that is fixed at build time. The below-watermark flag and the full flag also appear at fixed positions in a small flag vector, which the interrupt logic next to this block decodes.

Top module: `txq_wm_fifo`

## Requirements
- R1: After reset the queue is empty and not full, the watermark reads back as 1, below_wm is 1 and overflow is 0.
- R2: Bytes leave the queue in the order they were accepted. While the queue is not empty, pop_data shows the oldest byte, and asserting pop removes that byte at the clock edge.
- R3: When DEPTH bytes are held, full is 1. A write in that state is dropped and leaves the contents unchanged. overflow is 1 in the cycle after each dropped write and is 0 otherwise.
- R4: While the queue is empty, pop_data reads 0. A pop in that state changes no flag and no content.
- R5: A watermark write keeps only the low log2(DEPTH) bits of wm_wdata, and wm_rdata returns them zero-extended. Writing 0xFFFF therefore reads back DEPTH-1.
- R6: below_wm is 1 exactly when the current fill count is strictly less than the stored watermark. It follows every change of level or watermark from the next cycle on.
- R7: irq_flags bit 3 equals full, bit 2 equals below_wm, and bits 1 and 0 are 0.
- R8: A write and a pop in the same cycle, when the queue is neither empty nor full, leave the fill count unchanged. The popped byte leaves and the written byte joins the tail. A write and a pop in the same cycle on an empty queue accept the byte. The same pair on a full queue removes the head and drops the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Push request from the register bus |
| wr_data | input | 8 | Byte to push |
| pop | input | 1 | Pop request from the serial engine |
| pop_data | output | 8 | Oldest queued byte, 0 when empty |
| wm_wr | input | 1 | Watermark register write strobe |
| wm_wdata | input | 16 | Watermark write value, truncated on store |
| wm_rdata | output | 16 | Watermark read-back, zero-extended |
| full | output | 1 | Queue holds DEPTH bytes |
| empty | output | 1 | Queue holds no bytes |
| below_wm | output | 1 | Fill count below the watermark |
| overflow | output | 1 | One-cycle pulse after a dropped write |
| irq_flags | output | 4 | Flag vector: bit 3 full, bit 2 below-watermark |

## Verification
A fill counter that has drifted shows up first on below_wm. Every watermark value from 1 to DEPTH-1 is swept against every fill level, so a wrong count makes the flag differ from count < watermark within one cycle of the slip. A broken read or write pointer shows up as a wrong or reordered byte at pop_data on the next drain. Truncation faults in the watermark register show in wm_rdata on the cycle after the write, and they are checked over all sixteen low patterns and all ones.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int BYTE_W     = 8;
  localparam int REG_W      = 16;
  localparam int FLAG_W     = 4;
  localparam int FLAG_BELOW = 2;
  localparam int FLAG_FULL  = 3;

  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (push_ok) wp_d = wp_q + AW'(1);
    if (pop_ok)  rp_d = rp_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  // Storage has no reset; only written slots are ever read out.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= wdata;
  end

  assign head = mem[rp_q];
endmodule

// File: rtl/txq_level.sv
module txq_level #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          empty,
  output logic          overflow
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_req & ~full;
  assign pop_ok  = pop_req & ~empty;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
    ovf_d = push_req & full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign fill     = cnt_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/txq_wmark.sv
module txq_wmark #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  input  logic [CW-1:0] fill,
  output logic [AW-1:0] level,
  output logic          below
);
  logic [AW-1:0] wm_q, wm_d;

  always_comb begin
    wm_d = wm_q;
    if (wr) wm_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wm_q <= AW'(1);
    else        wm_q <= wm_d;
  end

  assign level = wm_q;
  assign below = (fill < {1'b0, wm_q});
endmodule

// File: rtl/txq_wm_fifo.sv
module txq_wm_fifo
  import txq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] pop_data,
  input  logic              wm_wr,
  input  logic [REG_W-1:0]  wm_wdata,
  output logic [REG_W-1:0]  wm_rdata,
  output logic              full,
  output logic              empty,
  output logic              below_wm,
  output logic              overflow,
  output logic [FLAG_W-1:0] irq_flags
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic          push_ok, pop_ok;
  logic [CW-1:0] fill_cnt;
  logic [AW-1:0] wm_level;
  byte_t         head;
  logic          unused_wm_hi;

  assign unused_wm_hi = ^wm_wdata[REG_W-1:AW];

  txq_level #(.DEPTH(DEPTH)) i_level (
    .clk(clk), .rst_n(rst_q), .push_req(wr_en), .pop_req(pop),
    .push_ok(push_ok), .pop_ok(pop_ok), .fill(fill_cnt),
    .full(full), .empty(empty), .overflow(overflow)
  );

  txq_store #(.DEPTH(DEPTH), .DW(BYTE_W)) i_store (
    .clk(clk), .rst_n(rst_q), .push_ok(push_ok), .pop_ok(pop_ok),
    .wdata(wr_data), .head(head)
  );

  txq_wmark #(.DEPTH(DEPTH)) i_wmark (
    .clk(clk), .rst_n(rst_q), .wr(wm_wr), .wdata(wm_wdata[AW-1:0]),
    .fill(fill_cnt), .level(wm_level), .below(below_wm)
  );

  assign pop_data = empty ? '0 : head;
  assign wm_rdata = {{(REG_W-AW){1'b0}}, wm_level};

  always_comb begin
    irq_flags             = '0;
    irq_flags[FLAG_BELOW] = below_wm;
    irq_flags[FLAG_FULL]  = full;
  end
endmodule

// File: rtl/txq_wm_fifo_chk.sv
module txq_wm_fifo_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_q,
  input logic          wr_en,
  input logic          pop,
  input logic          wm_wr,
  input logic [15:0]   wm_rdata,
  input logic          full,
  input logic          empty,
  input logic          below_wm,
  input logic          overflow,
  input logic [CW-1:0] fill
);
  p_full_empty_excl_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !(full && empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && full) |=> overflow);

  p_overflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_q)
    overflow |-> $past(wr_en && full));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && full && !pop) |=> full);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (empty && pop && !wr_en) |=> empty);

  p_wm_hold_r5: assert property (@(posedge clk) disable iff (!rst_q)
    !wm_wr |=> $stable(wm_rdata));

  p_below_mono_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && !pop && !wm_wr && !below_wm) |=> !below_wm);

  p_pair_hold_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && pop && !empty && !full) |=> $stable(fill));
endmodule

bind txq_wm_fifo txq_wm_fifo_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_q(rst_q), .wr_en(wr_en), .pop(pop), .wm_wr(wm_wr),
  .wm_rdata(wm_rdata), .full(full), .empty(empty), .below_wm(below_wm),
  .overflow(overflow), .fill(fill_cnt)
);

// File: tb/test_txq_wm_fifo.sv
module test_txq_wm_fifo;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        wr_en, pop, wm_wr;
  logic [7:0]  wr_data, pop_data;
  logic [15:0] wm_wdata, wm_rdata;
  logic        full, empty, below_wm, overflow;
  logic [3:0]  irq_flags;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mq[$];
  int  wm_m;
  bit  ovf_m;
  bit  done = 0;

  txq_wm_fifo #(.DEPTH(DEPTH)) i_txq_wm_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
    .pop_data(pop_data), .wm_wr(wm_wr), .wm_wdata(wm_wdata),
    .wm_rdata(wm_rdata), .full(full), .empty(empty), .below_wm(below_wm),
    .overflow(overflow), .irq_flags(irq_flags)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Flags against the model after an edge.
  task automatic chk_state(input string req);
    int n = mq.size();
    chk(req, "empty", int'(empty), int'(n == 0));
    chk(req, "full", int'(full), int'(n == DEPTH));
    chk("R6", "below_wm", int'(below_wm), int'(n < wm_m));
    chk("R3", "overflow", int'(overflow), int'(ovf_m));
    chk("R7", "irq_flags", int'(irq_flags),
        ((n == DEPTH) ? 8 : 0) + ((n < wm_m) ? 4 : 0));
    if (n == 0) chk("R4", "pop_data empty", int'(pop_data), 0);
    else        chk("R2", "head", int'(pop_data), int'(mq[0]));
  endtask

  task automatic cyc(input bit w, input logic [7:0] d, input bit p,
                     input bit ww, input logic [15:0] wd, input string req);
    int n;
    @(negedge clk);
    wr_en = w; wr_data = d; pop = p; wm_wr = ww; wm_wdata = wd;
    #1;
    n = mq.size();
    if (p && n == 0) chk("R4", "pop on empty data", int'(pop_data), 0);
    if (p && n > 0)  chk("R2", "popped byte", int'(pop_data), int'(mq[0]));
    @(posedge clk);
    #1;
    if (p && n > 0) void'(mq.pop_front());
    if (w && n < DEPTH) mq.push_back(d);
    ovf_m = w && (n == DEPTH);
    if (ww) wm_m = int'(wd) & (DEPTH - 1);
    wr_en = 0; pop = 0; wm_wr = 0;
    chk_state(req);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog actual=hung expected=done");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wr_en = 0; pop = 0; wm_wr = 0; wr_data = 0; wm_wdata = 0;
    rst_n = 0; wm_m = 1; ovf_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "wm_rdata", int'(wm_rdata), 1);
    chk("R1", "below_wm", int'(below_wm), 1);
    chk("R1", "overflow", int'(overflow), 0);
    chk("R7", "irq_flags reset", int'(irq_flags), 4);

    // R5: depth discovery and truncation sweep
    cyc(0, 0, 0, 1, 16'hFFFF, "R5");
    chk("R5", "all ones readback", int'(wm_rdata), DEPTH - 1);
    for (int v = 0; v < 16; v++) begin
      cyc(0, 0, 0, 1, 16'(v * 16'h1111 + 16'h0ff0 * (v & 1)), "R5");
      chk("R5", "truncated readback", int'(wm_rdata),
          (v * 16'h1111 + 16'h0ff0 * (v & 1)) & 16'hFFFF & (DEPTH - 1));
    end

    // R2 R3 R6: every watermark against every fill level, then drain
    for (int w = 1; w < DEPTH; w++) begin
      cyc(0, 0, 0, 1, 16'(w), "R6");
      for (int i = 0; i < DEPTH; i++) cyc(1, 8'(w * 16 + i), 0, 0, 0, "R2");
      cyc(1, 8'hEE, 0, 0, 0, "R3");
      cyc(1, 8'hDD, 0, 0, 0, "R3");
      cyc(0, 0, 0, 0, 0, "R3");
      for (int i = 0; i <= DEPTH; i++) cyc(0, 0, 1, 0, 0, "R2");
    end

    // R4: pops on an empty queue
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R4");

    // R8: paired push and pop at each case
    cyc(1, 8'h11, 1, 0, 0, "R8");
    cyc(1, 8'h22, 0, 0, 0, "R8");
    cyc(1, 8'h33, 0, 0, 0, "R8");
    for (int i = 0; i < 12; i++) cyc(1, 8'(8'h80 + i), 1, 0, 0, "R8");
    while (mq.size() < DEPTH) cyc(1, 8'(8'h40 + mq.size()), 0, 0, 0, "R8");
    cyc(1, 8'h99, 1, 0, 0, "R8");
    cyc(1, 8'hAA, 0, 0, 0, "R8");
    // watermark change while level is fixed
    cyc(0, 0, 0, 1, 16'hFFFF, "R6");
    while (mq.size() > 0) cyc(0, 0, 1, 0, 0, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule